// File: doc/BRIEF.md
# Accumulator ALU with Carry and Zero Flags

This block is the arithmetic-logic stage of a small byte-wide controller. It holds an 8-bit accumulator and an 8-bit secondary register, together with a carry flag and a zero flag. Each accepted operation reads the accumulator or the secondary register, combines it with the operand byte presented on the port, and writes the result and flags back on the same clock edge. The caller decides where the operand comes from: a banked register or an immediate byte. The caller marks the source with a form bit.

Register-form operations occupy the stage for one cycle. Immediate-form operations occupy it for two cycles. During the second cycle the stage reports busy and ignores any strobe. The flag rules differ by operation. After a subtraction, carry means "no borrow". AND and OR leave carry unchanged. XOR forces carry low.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, the secondary register, carry, zero and busy.
- R2: Code 0 (add) forms the 9-bit sum of the accumulator and the operand. The accumulator takes the low 8 bits, carry takes bit 8, and zero is set when the new accumulator is 0.
- R3: Code 1 (subtract) sets carry when the accumulator is greater than or equal to the operand. The accumulator takes the difference modulo 256, and zero reflects the new accumulator.
- R4: Code 2 (AND) and code 3 (OR) write the accumulator and zero. Carry keeps its previous value.
- R5: Code 4 (XOR) writes the accumulator and zero, and clears carry.
- R6: Code 5 (increment), code 6 (decrement) and code 7 (bitwise complement) act on the accumulator modulo 256. They update zero only, and carry is unchanged.
- R7: Code 8 rotates the accumulator right by one bit and code 9 rotates it left by one bit. Both are circular 8-bit rotates that do not pass through carry. They update zero, and carry is unchanged.
- R8: Code 10 (add to secondary) adds the operand to the secondary register. The secondary register takes the low 8 bits, carry takes bit 8, and zero is set when the new secondary value is 0. The accumulator is unchanged.
- R9: Codes 11 to 15 change neither register nor any flag.
- R10: An accepted strobe with the immediate-form bit set raises busy for exactly the next cycle. A strobe arriving while busy is high changes nothing. A register-form operation never raises busy.
- R11: With the strobe low, registers and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Write strobe: perform op_code this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_imm | input | 1 | 1 = immediate-form operand (two-cycle occupancy) |
| operand | input | 8 | Operand byte chosen by the caller |
| acc_out | output | 8 | Accumulator |
| breg_out | output | 8 | Secondary register |
| carry | output | 1 | Carry flag |
| zero | output | 1 | Zero flag |
| busy | output | 1 | Second cycle of an immediate-form operation |

## Verification
The assertions take for granted that the caller keeps the strobe and the operation inputs at known levels whenever reset is high. They also take for granted that a strobe in the busy cycle may be presented, and that it must then be dropped rather than queued. The stimulus always drives known values. It deliberately issues strobes during busy cycles, and it mixes register and immediate forms so that the ignore path is reached often. Directed vectors cover the carry and zero edges: a sum that wraps to zero, a subtraction of equal values, a subtraction that borrows, and rotates of single-bit patterns.

// File: rtl/acc_alu_pkg.sv
// Shared operation encoding for the accumulator ALU.
package acc_alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_CPL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ADDB = 4'd10
    } alu_op_e;
endpackage

// File: rtl/acc_alu_core.sv
// Combinational datapath: computes next accumulator, secondary register
// and flags from the current state and one operation.
// Assumes: op codes outside the enum leave everything unchanged.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   a_cur,
    input  logic [DW-1:0]   b_cur,
    input  logic [DW-1:0]   opnd,
    input  logic            c_cur,
    input  logic            z_cur,
    output logic [DW-1:0]   a_nxt,
    output logic [DW-1:0]   b_nxt,
    output logic            c_nxt,
    output logic            z_nxt
);
    localparam int SW = DW + 1;
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [SW-1:0] sum_a;
    logic [SW-1:0] sum_b;

    // Purpose: shared wide adders for the two carry-producing additions.
    always_comb begin
        sum_a = {1'b0, a_cur} + {1'b0, opnd};
        sum_b = {1'b0, b_cur} + {1'b0, opnd};
    end

    // Purpose: per-operation result and flag selection.
    always_comb begin
        a_nxt = a_cur;
        b_nxt = b_cur;
        c_nxt = c_cur;
        z_nxt = z_cur;
        case (alu_op_e'(op))
            OP_ADD: begin
                a_nxt = sum_a[DW-1:0];
                c_nxt = sum_a[DW];
                z_nxt = (sum_a[DW-1:0] == '0);
            end
            OP_SUB: begin
                a_nxt = a_cur - opnd;
                c_nxt = (a_cur >= opnd);
                z_nxt = (a_cur == opnd);
            end
            OP_AND: begin
                a_nxt = a_cur & opnd;
                z_nxt = ((a_cur & opnd) == '0);
            end
            OP_OR: begin
                a_nxt = a_cur | opnd;
                z_nxt = ((a_cur | opnd) == '0);
            end
            OP_XOR: begin
                a_nxt = a_cur ^ opnd;
                c_nxt = 1'b0;
                z_nxt = (a_cur == opnd);
            end
            OP_INC: begin
                a_nxt = a_cur + ONE;
                z_nxt = ((a_cur + ONE) == '0);
            end
            OP_DEC: begin
                a_nxt = a_cur - ONE;
                z_nxt = (a_cur == ONE);
            end
            OP_CPL: begin
                a_nxt = ~a_cur;
                z_nxt = (a_cur == '1);
            end
            OP_ROR: begin
                a_nxt = {a_cur[0], a_cur[DW-1:1]};
                z_nxt = (a_cur == '0);
            end
            OP_ROL: begin
                a_nxt = {a_cur[DW-2:0], a_cur[DW-1]};
                z_nxt = (a_cur == '0);
            end
            OP_ADDB: begin
                b_nxt = sum_b[DW-1:0];
                c_nxt = sum_b[DW];
                z_nxt = (sum_b[DW-1:0] == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_occupancy.sv
// Occupancy tracker: accepts a strobe only when idle; an immediate-form
// operation holds the stage busy for one extra cycle.
// Assumes: synchronous active-low reset.
module acc_alu_occupancy (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic imm,
    output logic accept,
    output logic busy
);
    logic busy_q;

    // Purpose: a strobe is taken only outside the busy cycle.
    always_comb accept = valid & ~busy_q;

    // Purpose: mark the second cycle of an immediate-form operation.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= accept & imm;
    end

    assign busy = busy_q;
endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU top: holds A, B, carry and zero and commits the
// datapath result on each accepted strobe.
// Assumes: operand source selection is done by the caller.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            op_imm,
    input  logic [DW-1:0]   operand,
    output logic [DW-1:0]   acc_out,
    output logic [DW-1:0]   breg_out,
    output logic            carry,
    output logic            zero,
    output logic            busy
);
    logic [DW-1:0] a_q, b_q, a_d, b_d;
    logic          c_q, z_q, c_d, z_d;
    logic          accept;

    acc_alu_occupancy u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (op_valid),
        .imm    (op_imm),
        .accept (accept),
        .busy   (busy)
    );

    acc_alu_core #(.DW(DW)) u_core (
        .op    (op_code),
        .a_cur (a_q),
        .b_cur (b_q),
        .opnd  (operand),
        .c_cur (c_q),
        .z_cur (z_q),
        .a_nxt (a_d),
        .b_nxt (b_d),
        .c_nxt (c_d),
        .z_nxt (z_d)
    );

    // Purpose: architectural state, written only on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= 1'b0;
            z_q <= 1'b0;
        end else if (accept) begin
            a_q <= a_d;
            b_q <= b_d;
            c_q <= c_d;
            z_q <= z_d;
        end
    end

    assign acc_out  = a_q;
    assign breg_out = b_q;
    assign carry    = c_q;
    assign zero     = z_q;
endmodule

// File: rtl/acc_alu_checker.sv
// Property checker for acc_alu, bound to every instance.
module acc_alu_checker
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [OP_W-1:0] op_code,
    input logic            op_imm,
    input logic [DW-1:0]   operand,
    input logic [DW-1:0]   acc_out,
    input logic [DW-1:0]   breg_out,
    input logic            carry,
    input logic            zero,
    input logic            busy
);
    logic taken;
    assign taken = op_valid && !busy;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && breg_out == '0 && !carry && !zero && !busy)); // R1
    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        taken && (op_code == OP_AND || op_code == OP_OR) |=> $stable(carry)); // R4
    AST_XOR_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        taken && op_code == OP_XOR |=> !carry); // R5
    AST_ACC_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        taken && op_code <= OP_ROL |=> zero == (acc_out == '0)); // R2
    AST_ADDB_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        taken && op_code == OP_ADDB |=> $stable(acc_out) && zero == (breg_out == '0)); // R8
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R10
    AST_IMM_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        taken && op_imm |=> busy); // R10
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc_out) && $stable(breg_out) && $stable(carry) && $stable(zero)); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc_out) && $stable(breg_out) && $stable(carry) && $stable(zero)); // R11
endmodule

bind acc_alu acc_alu_checker #(.DW(DW)) u_chk (.*);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = '0;
    logic          op_imm = 1'b0;
    logic [DW-1:0] operand = '0;
    logic [DW-1:0] acc_out, breg_out;
    logic          carry, zero, busy;

    int vectors = 0;
    int errors  = 0;
    int m_a = 0, m_b = 0, m_c = 0, m_z = 0, m_busy = 0;

    always #4 clk = ~clk;

    acc_alu #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_imm(op_imm), .operand(operand), .acc_out(acc_out),
        .breg_out(breg_out), .carry(carry), .zero(zero), .busy(busy)
    );

    function automatic string tag_of(input bit v, input bit bz, input int op);
        if (!v) return "R11";
        if (bz) return "R10";
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5, 6, 7: return "R6";
            8, 9: return "R7";
            10: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag);
        vectors++;
        if (acc_out !== m_a[7:0] || breg_out !== m_b[7:0] || carry !== m_c[0] ||
            zero !== m_z[0] || busy !== m_busy[0]) begin
            errors++;
            $display("FAIL %s: got a=%02h b=%02h c=%0b z=%0b busy=%0b, expected a=%02h b=%02h c=%0d z=%0d busy=%0d",
                     tag, acc_out, breg_out, carry, zero, busy, m_a, m_b, m_c, m_z, m_busy);
        end
    endtask

    // Apply one vector after a falling edge, advance the model, check at the next falling edge.
    task automatic step(input bit v, input int op, input bit imm, input int d);
        string tag;
        int r;
        bit take;
        tag = tag_of(v, m_busy != 0, op);
        op_valid = v; op_code = op[3:0]; op_imm = imm; operand = d[7:0];
        take = v && (m_busy == 0);
        if (take) begin
            case (op)
                0: begin r = m_a + d; m_a = r & 255; m_c = r >> 8; m_z = (m_a == 0); end
                1: begin m_c = (m_a >= d); m_a = (m_a - d) & 255; m_z = (m_a == 0); end
                2: begin m_a = m_a & d; m_z = (m_a == 0); end
                3: begin m_a = m_a | d; m_z = (m_a == 0); end
                4: begin m_a = m_a ^ d; m_c = 0; m_z = (m_a == 0); end
                5: begin m_a = (m_a + 1) & 255; m_z = (m_a == 0); end
                6: begin m_a = (m_a + 255) & 255; m_z = (m_a == 0); end
                7: begin m_a = 255 - m_a; m_z = (m_a == 0); end
                8: begin m_a = (m_a >> 1) | ((m_a & 1) << 7); m_z = (m_a == 0); end
                9: begin m_a = ((m_a << 1) & 255) | (m_a >> 7); m_z = (m_a == 0); end
                10: begin r = m_b + d; m_b = r & 255; m_c = r >> 8; m_z = (m_b == 0); end
                default: ;
            endcase
        end
        m_busy = (take && imm) ? 1 : 0;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        // R2 directed: wrap to zero with carry
        step(1, 3, 0, 8'hFF);
        step(1, 0, 0, 1);
        step(1, 0, 1, 8'h80);
        // R10 strobe during busy is dropped
        step(1, 4, 0, 8'h80);
        // R3 equal, then borrow
        step(1, 1, 0, 8'h80);
        step(1, 1, 0, 1);
        // R4 carry held across AND/OR
        step(1, 2, 0, 8'h0F);
        step(1, 3, 0, 0);
        // R5
        step(1, 4, 1, 8'h0F);
        step(0, 0, 0, 0);
        // R7 single-bit rotates
        step(1, 2, 0, 0);
        step(1, 3, 0, 1);
        step(1, 8, 0, 0);
        step(1, 9, 0, 0);
        step(1, 9, 0, 0);
        // R6
        step(1, 7, 0, 0);
        step(1, 5, 0, 0);
        step(1, 6, 0, 0);
        // R8 and R9
        step(1, 10, 0, 8'hFF);
        step(1, 10, 1, 1);
        step(1, 12, 0, 8'h55);
        step(1, 15, 1, 8'hAA);
        // Mixed stimulus
        for (int i = 0; i < 3000; i++)
            step(($urandom % 5) != 0, $urandom % 16, $urandom % 2, $urandom % 256);
        // R1 reset mid-run
        rst_n = 1'b0; op_valid = 1'b0;
        m_a = 0; m_b = 0; m_c = 0; m_z = 0; m_busy = 0;
        @(negedge clk);
        compare("R1");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule